// File: doc/BRIEF.md
# Pipelined Flash Word Programmer

This block takes 16-bit word writes from a processor and commits them to a modelled flash array. Programming a word takes a fixed, parameterised number of cycles. A single holding slot lets the next word be accepted while the current one is still programming. The array has two regions. The main array is split into equal sectors, and each sector has its own write-enable input. The information space holds several equal blocks and is reached through an address register followed by a data register. Programming can only pull bits low: each word ends up holding the AND of its old contents and the new data.

Software raises the program-enable input and then issues word writes. It watches the busy and full flags and reads the sticky error flag at the end. Every request passes a layered set of checks. Any request that fails a check is refused and raises the error flag. These checks are the global write-protect input, word width and alignment, the per-sector enable, the boot-area bound, and the ban on information block 0. A combinational read port exposes the array contents. Erase and read-path timing are not part of this block.

Top module: `flash_word_prog`

## Requirements
- R1: After reset, busy, full and the error flag are low, and every word of both regions reads 0xFFFF.
- R2: With program enable high and every check passed, a write with target code 0 (main array, word index = byte address bits above bit 0) makes busy read high for exactly PROG_CYCLES cycles, and the word is then updated.
- R3: Programming stores the bitwise AND of the old and new data, so bits can go from 1 to 0 but never from 0 to 1.
- R4: While program enable is low, a write with target code 0 or 2 has no effect: busy stays low, the error flag stays low and the array is unchanged.
- R5: While global write protect is high, every program request is refused: the error flag sets and no word changes.
- R6: A main-array write is refused when the write-enable bit of its sector is low (sector = word index / SECT_WORDS).
- R7: A main-array write is refused when its word index is below boot_top_i. An index equal to boot_top_i is accepted.
- R8: A request is refused unless both byte enables are set and the byte address bit 0 is zero.
- R9: A write with target code 1 loads the info address register from the write data (a byte address; info word = bits above bit 0, block = info word / INFO_WORDS). A write with target code 2 then programs that info word with the write data. Info block 0 is always refused.
- R10: A request accepted while busy, with the slot empty, sets full. Full clears when the held word moves into programming. Busy stays high until both words are done, which is 2*PROG_CYCLES-1 cycles after the second request.
- R11: A program request that arrives while full is high is dropped, its word is not changed, and the error flag sets.
- R12: A request that arrives in the same cycle as the active word finishes, with the slot empty, goes straight into programming: full stays low and busy lasts PROG_CYCLES more cycles.
- R13: The error flag stays set until a cycle with perr_clr_i high and no new refusal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_en_i | input | 1 | Program enable |
| wp_i | input | 1 | Global write protect |
| sect_we_i | input | MAIN_WORDS/SECT_WORDS | Per-sector write enables |
| boot_top_i | input | $clog2(MAIN_WORDS)+1 | First main word index outside the boot area |
| wr_en_i | input | 1 | Write strobe |
| wr_tgt_i | input | 2 | Target: 0 main array, 1 info address register, 2 info data register |
| wr_addr_i | input | $clog2(MAIN_WORDS)+1 | Main-array byte address |
| wr_be_i | input | 2 | Byte enables |
| wr_data_i | input | 16 | Write data |
| perr_clr_i | input | 1 | Clears the error flag |
| rd_space_i | input | 1 | Read region: 0 main, 1 info |
| rd_addr_i | input | $clog2(MAIN_WORDS) | Read word index within the region |
| rd_data_o | output | 16 | Word read |
| busy_o | output | 1 | A word is programming |
| full_o | output | 1 | Holding slot occupied |
| perr_o | output | 1 | Sticky programming error |

## Verification
Two events can coincide in a single cycle: the active word finishing, and a new request arriving. The bench provokes this by timing a second write to land exactly PROG_CYCLES cycles after the first. It expects the second word to bypass the slot, with full low, busy lasting PROG_CYCLES more cycles and both words correct. The bench also times a third request to arrive while the slot is still occupied. That request must be dropped with the error flag set, and its target word must stay erased.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    TGT_MAIN  = 2'd0,
    TGT_IADDR = 2'd1,
    TGT_IDATA = 2'd2,
    TGT_NONE  = 2'd3
  } tgt_e;
endpackage

// File: rtl/flash_prog_guard.sv
module flash_prog_guard
  import flash_prog_pkg::*;
#(
  parameter int MAIN_WORDS = 256,
  parameter int SECT_WORDS = 32,
  parameter int INFO_BLKS  = 2,
  parameter int INFO_WORDS = 16,
  localparam int MW_W  = $clog2(MAIN_WORDS),
  localparam int NSECT = MAIN_WORDS / SECT_WORDS,
  localparam int IT    = INFO_BLKS * INFO_WORDS,
  localparam int IW_W  = $clog2(IT),
  localparam int IDX_W = $clog2(MAIN_WORDS + IT)
) (
  input  logic             wr_en_i,
  input  tgt_e             tgt_i,
  input  logic [MW_W:0]    wr_addr_i,
  input  logic [1:0]       be_i,
  input  logic [IW_W:0]    iaddr_i,
  input  logic             prog_en_i,
  input  logic             wp_i,
  input  logic [NSECT-1:0] sect_we_i,
  input  logic [MW_W:0]    boot_top_i,
  output logic             start_o,
  output logic             refuse_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam int SW_W = $clog2(SECT_WORDS);
  localparam int IB_W = $clog2(INFO_WORDS);

  logic [MW_W-1:0]      main_word;
  logic [MW_W-SW_W-1:0] sect;
  logic [IW_W-1:0]      info_word;
  logic [IW_W-IB_W-1:0] blk;
  logic                 is_info, prog_req, word_ok, main_ok, info_ok, ok;

  assign main_word = wr_addr_i[MW_W:1];
  assign sect      = main_word[MW_W-1:SW_W];
  assign info_word = iaddr_i[IW_W:1];
  assign blk       = info_word[IW_W-1:IB_W];
  assign is_info   = (tgt_i == TGT_IDATA);
  assign prog_req  = wr_en_i && prog_en_i && (tgt_i == TGT_MAIN || is_info);

  always_comb begin
    word_ok = (be_i == 2'b11) && !(is_info ? iaddr_i[0] : wr_addr_i[0]);
    main_ok = sect_we_i[sect] && ({1'b0, main_word} >= boot_top_i);
    info_ok = (blk != '0);
    ok      = !wp_i && word_ok && (is_info ? info_ok : main_ok);
  end

  assign start_o  = prog_req && ok;
  assign refuse_o = prog_req && !ok;
  assign idx_o    = is_info ? IDX_W'(MAIN_WORDS) + IDX_W'(info_word) : IDX_W'(main_word);
endmodule

// File: rtl/flash_prog_pipe.sv
module flash_prog_pipe #(
  parameter int DATA_W      = 16,
  parameter int IDX_W       = 9,
  parameter int PROG_CYCLES = 8,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              refuse_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              perr_clr_i,
  output logic              busy_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_idx_o,
  output logic [DATA_W-1:0] commit_data_o
);
  logic              act_v, buf_v, perr_q;
  logic [IDX_W-1:0]  act_idx, buf_idx;
  logic [DATA_W-1:0] act_data, buf_data;
  logic [CNT_W-1:0]  cnt;
  logic              done, drop;

  assign done = act_v && (cnt == CNT_W'(1));
  assign drop = start_i && buf_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_v    <= 1'b0;
      buf_v    <= 1'b0;
      act_idx  <= '0;
      buf_idx  <= '0;
      act_data <= '0;
      buf_data <= '0;
      cnt      <= '0;
    end else begin
      if (done) begin
        if (buf_v) begin
          act_idx  <= buf_idx;
          act_data <= buf_data;
          cnt      <= CNT_W'(PROG_CYCLES);
          buf_v    <= 1'b0;
        end else begin
          act_v <= 1'b0;
        end
      end else if (act_v) begin
        cnt <= cnt - CNT_W'(1);
      end
      // a finishing word with an empty slot frees the programmer this cycle
      if (start_i && !buf_v) begin
        if (!act_v || done) begin
          act_v    <= 1'b1;
          act_idx  <= idx_i;
          act_data <= data_i;
          cnt      <= CNT_W'(PROG_CYCLES);
        end else begin
          buf_v    <= 1'b1;
          buf_idx  <= idx_i;
          buf_data <= data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                perr_q <= 1'b0;
    else if (refuse_i || drop)  perr_q <= 1'b1;
    else if (perr_clr_i)        perr_q <= 1'b0;
  end

  assign busy_o        = act_v;
  assign full_o        = buf_v;
  assign perr_o        = perr_q;
  assign commit_o      = done;
  assign commit_idx_o  = act_idx;
  assign commit_data_o = act_data;
endmodule

// File: rtl/flash_prog_array.sv
module flash_prog_array #(
  parameter int DATA_W = 16,
  parameter int WORDS  = 288,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  commit_idx_i,
  input  logic [DATA_W-1:0] commit_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit_i) begin
      mem[commit_idx_i] <= mem[commit_idx_i] & commit_data_i;
    end
  end

  assign rd_data_o = mem[rd_idx_i];
endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
  import flash_prog_pkg::*;
#(
  parameter int MAIN_WORDS  = 256,
  parameter int SECT_WORDS  = 32,
  parameter int INFO_BLKS   = 2,
  parameter int INFO_WORDS  = 16,
  parameter int PROG_CYCLES = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               prog_en_i,
  input  logic                               wp_i,
  input  logic [MAIN_WORDS/SECT_WORDS-1:0]   sect_we_i,
  input  logic [$clog2(MAIN_WORDS):0]        boot_top_i,
  input  logic                               wr_en_i,
  input  logic [1:0]                         wr_tgt_i,
  input  logic [$clog2(MAIN_WORDS):0]        wr_addr_i,
  input  logic [1:0]                         wr_be_i,
  input  logic [15:0]                        wr_data_i,
  input  logic                               perr_clr_i,
  input  logic                               rd_space_i,
  input  logic [$clog2(MAIN_WORDS)-1:0]      rd_addr_i,
  output logic [15:0]                        rd_data_o,
  output logic                               busy_o,
  output logic                               full_o,
  output logic                               perr_o
);
  localparam int IT    = INFO_BLKS * INFO_WORDS;
  localparam int IW_W  = $clog2(IT);
  localparam int TOT   = MAIN_WORDS + IT;
  localparam int IDX_W = $clog2(TOT);

  tgt_e              tgt;
  logic [IW_W:0]     iaddr_q;
  logic              prog_start, prog_refuse, commit;
  logic [IDX_W-1:0]  req_idx, commit_idx, rd_idx;
  logic [DATA_W-1:0] commit_data;

  assign tgt = tgt_e'(wr_tgt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            iaddr_q <= '0;
    else if (wr_en_i && tgt == TGT_IADDR)   iaddr_q <= wr_data_i[IW_W:0];
  end

  flash_prog_guard #(
    .MAIN_WORDS(MAIN_WORDS), .SECT_WORDS(SECT_WORDS),
    .INFO_BLKS(INFO_BLKS), .INFO_WORDS(INFO_WORDS)
  ) u_guard (
    .wr_en_i   (wr_en_i),
    .tgt_i     (tgt),
    .wr_addr_i (wr_addr_i),
    .be_i      (wr_be_i),
    .iaddr_i   (iaddr_q),
    .prog_en_i (prog_en_i),
    .wp_i      (wp_i),
    .sect_we_i (sect_we_i),
    .boot_top_i(boot_top_i),
    .start_o   (prog_start),
    .refuse_o  (prog_refuse),
    .idx_o     (req_idx)
  );

  flash_prog_pipe #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PROG_CYCLES(PROG_CYCLES)
  ) u_pipe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (prog_start),
    .refuse_i     (prog_refuse),
    .idx_i        (req_idx),
    .data_i       (wr_data_i),
    .perr_clr_i   (perr_clr_i),
    .busy_o       (busy_o),
    .full_o       (full_o),
    .perr_o       (perr_o),
    .commit_o     (commit),
    .commit_idx_o (commit_idx),
    .commit_data_o(commit_data)
  );

  assign rd_idx = rd_space_i ? IDX_W'(MAIN_WORDS) + IDX_W'(rd_addr_i[IW_W-1:0])
                             : IDX_W'(rd_addr_i);

  flash_prog_array #(.DATA_W(DATA_W), .WORDS(TOT)) u_array (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .commit_idx_i (commit_idx),
    .commit_data_i(commit_data),
    .rd_idx_i     (rd_idx),
    .rd_data_o    (rd_data_o)
  );
endmodule

// File: rtl/flash_word_prog_chk.sv
module flash_word_prog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       prog_en_i,
  input logic       wp_i,
  input logic       wr_en_i,
  input logic [1:0] wr_tgt_i,
  input logic       perr_clr_i,
  input logic       busy_o,
  input logic       full_o,
  input logic       perr_o,
  input logic       start_i
);
  logic prog_req;
  assign prog_req = wr_en_i && prog_en_i && (wr_tgt_i == 2'd0 || wr_tgt_i == 2'd2);

  assert_full_needs_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> busy_o);
  assert_full_rise_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(busy_o));
  assert_busy_drains_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(full_o));
  assert_drop_flags_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req && full_o |=> perr_o);
  assert_wp_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wp_i |-> !start_i);
  assert_pe_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_en_i |-> !start_i);
  assert_perr_sticky_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_o && !perr_clr_i |=> perr_o);
endmodule

bind flash_word_prog flash_word_prog_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prog_en_i (prog_en_i),
  .wp_i      (wp_i),
  .wr_en_i   (wr_en_i),
  .wr_tgt_i  (wr_tgt_i),
  .perr_clr_i(perr_clr_i),
  .busy_o    (busy_o),
  .full_o    (full_o),
  .perr_o    (perr_o),
  .start_i   (prog_start)
);

// File: tb/flash_word_prog_test.sv
module flash_word_prog_test;
  localparam int CLK_PERIOD = 10;
  localparam int MW = 256, SW = 32, IB = 2, IWD = 16, PC = 8;
  localparam int IT = IB * IWD;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        prog_en = 1'b0, wp = 1'b0, wr_en = 1'b0, perr_clr = 1'b0, rd_space = 1'b0;
  logic [7:0]  sect_we = '1;
  logic [8:0]  boot_top = '0, wr_addr = '0;
  logic [1:0]  wr_tgt = '0, wr_be = 2'b11;
  logic [15:0] wr_data = '0, rd_data;
  logic [7:0]  rd_addr = '0;
  logic        busy, full, perr;

  logic [15:0] exp_main [MW];
  logic [15:0] exp_info [IT];
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_word_prog #(.MAIN_WORDS(MW), .SECT_WORDS(SW), .INFO_BLKS(IB),
                    .INFO_WORDS(IWD), .PROG_CYCLES(PC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .prog_en_i(prog_en), .wp_i(wp),
    .sect_we_i(sect_we), .boot_top_i(boot_top), .wr_en_i(wr_en),
    .wr_tgt_i(wr_tgt), .wr_addr_i(wr_addr), .wr_be_i(wr_be),
    .wr_data_i(wr_data), .perr_clr_i(perr_clr), .rd_space_i(rd_space),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .busy_o(busy),
    .full_o(full), .perr_o(perr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [1:0] t, input logic [8:0] a, input logic [1:0] be,
                    input logic [15:0] d);
    wr_en = 1'b1; wr_tgt = t; wr_addr = a; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic sp, input int a, output logic [15:0] v);
    rd_space = sp; rd_addr = 8'(a);
    #1 v = rd_data;
  endtask

  task automatic idle();
    while (busy) @(negedge clk);
  endtask

  task automatic clr_perr();
    perr_clr = 1'b1; @(negedge clk); perr_clr = 1'b0;
  endtask

  task automatic chk_main(input string req, input int w);
    logic [15:0] v;
    rd(1'b0, w, v);
    chk(req, {16'h0, v}, {16'h0, exp_main[w]});
  endtask

  task automatic chk_info(input string req, input int w);
    logic [15:0] v;
    rd(1'b1, w, v);
    chk(req, {16'h0, v}, {16'h0, exp_info[w]});
  endtask

  function automatic bit main_ok(input logic [8:0] a, input logic [1:0] be);
    int w = int'(a[8:1]);
    return !wp && be == 2'b11 && !a[0] && sect_we[w / SW] && (w >= int'(boot_top));
  endfunction

  function automatic bit info_ok(input logic [5:0] ia, input logic [1:0] be);
    int w = int'(ia[5:1]);
    return !wp && be == 2'b11 && !ia[0] && (w / IWD) != 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, nf;
    logic [15:0] v;
    void'($urandom(32'h5EED));
    for (int i = 0; i < MW; i++) exp_main[i] = 16'hFFFF;
    for (int i = 0; i < IT; i++) exp_info[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 full", {31'h0, full}, 0);
    chk("R1 perr", {31'h0, perr}, 0);
    chk_main("R1 main erased", 255);
    chk_info("R1 info erased", 31);

    prog_en = 1'b1;
    // R2 basic write, busy length
    wr(2'd0, 9'd64, 2'b11, 16'hA5F0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R2 busy cycles", n, PC);
    exp_main[32] &= 16'hA5F0;
    chk_main("R2 word", 32);

    // R3 AND semantic
    wr(2'd0, 9'd64, 2'b11, 16'h0FFF); idle();
    exp_main[32] &= 16'h0FFF;
    chk("R3 and value", {16'h0, exp_main[32]}, 32'h05F0);
    chk_main("R3 word", 32);

    // R4 program enable low
    prog_en = 1'b0;
    wr(2'd0, 9'd80, 2'b11, 16'h0000);
    chk("R4 busy", {31'h0, busy}, 0);
    chk("R4 perr", {31'h0, perr}, 0);
    chk_main("R4 word", 40);
    prog_en = 1'b1;

    // R5 write protect, R13 stickiness
    wp = 1'b1;
    wr(2'd0, 9'd80, 2'b11, 16'h0000);
    chk("R5 perr", {31'h0, perr}, 1);
    chk("R5 busy", {31'h0, busy}, 0);
    chk_main("R5 word", 40);
    wp = 1'b0;
    repeat (3) @(negedge clk);
    chk("R13 sticky", {31'h0, perr}, 1);
    clr_perr();
    chk("R13 cleared", {31'h0, perr}, 0);

    // R6 sector enable
    sect_we[2] = 1'b0;
    wr(2'd0, 9'd140, 2'b11, 16'h1111);
    chk("R6 perr", {31'h0, perr}, 1);
    chk_main("R6 word", 70);
    sect_we[2] = 1'b1; clr_perr();

    // R7 boot bound
    boot_top = 9'd16;
    wr(2'd0, 9'd30, 2'b11, 16'h2222);
    chk("R7 perr below", {31'h0, perr}, 1);
    chk_main("R7 boot word", 15);
    clr_perr();
    wr(2'd0, 9'd32, 2'b11, 16'h3333); idle();
    exp_main[16] &= 16'h3333;
    chk("R7 perr at bound", {31'h0, perr}, 0);
    chk_main("R7 bound word", 16);
    boot_top = '0;

    // R8 alignment and width
    wr(2'd0, 9'd101, 2'b11, 16'h0000);
    chk("R8 odd perr", {31'h0, perr}, 1);
    chk_main("R8 odd word", 50);
    clr_perr();
    wr(2'd0, 9'd100, 2'b01, 16'h0000);
    chk("R8 be perr", {31'h0, perr}, 1);
    chk_main("R8 be word", 50);
    clr_perr();

    // R9 info path
    wr(2'd1, 9'd0, 2'b11, 16'd40);
    wr(2'd2, 9'd0, 2'b11, 16'h1234); idle();
    exp_info[20] &= 16'h1234;
    chk("R9 perr", {31'h0, perr}, 0);
    chk_info("R9 info word", 20);
    wr(2'd1, 9'd0, 2'b11, 16'd6);
    wr(2'd2, 9'd0, 2'b11, 16'h0000);
    chk("R9 block0 perr", {31'h0, perr}, 1);
    chk_info("R9 block0 word", 3);
    clr_perr();

    // R10 buffered second word
    wr(2'd0, 9'd200, 2'b11, 16'hF00F);
    wr(2'd0, 9'd202, 2'b11, 16'h0FF0);
    chk("R10 full set", {31'h0, full}, 1);
    n = 0; nf = 0;
    while (busy) begin n++; if (full) nf++; @(negedge clk); end
    chk("R10 busy span", n, 2 * PC - 1);
    chk("R10 full span", nf, PC - 1);
    exp_main[100] &= 16'hF00F; exp_main[101] &= 16'h0FF0;
    chk_main("R10 word a", 100);
    chk_main("R10 word b", 101);

    // R11 drop while full
    wr(2'd0, 9'd210, 2'b11, 16'h1000);
    wr(2'd0, 9'd212, 2'b11, 16'h2000);
    wr(2'd0, 9'd214, 2'b11, 16'h3000);
    chk("R11 perr", {31'h0, perr}, 1);
    idle();
    exp_main[105] &= 16'h1000; exp_main[106] &= 16'h2000;
    chk_main("R11 dropped word", 107);
    chk_main("R11 kept word", 106);
    clr_perr();

    // R12 request coincides with completion
    wr(2'd0, 9'd220, 2'b11, 16'hAAAA);
    repeat (PC - 1) @(negedge clk);
    wr(2'd0, 9'd222, 2'b11, 16'h5555);
    chk("R12 full", {31'h0, full}, 0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk("R12 busy span", n, PC);
    exp_main[110] &= 16'hAAAA; exp_main[111] &= 16'h5555;
    chk_main("R12 word a", 110);
    chk_main("R12 word b", 111);
    chk("R12 perr", {31'h0, perr}, 0);

    // random mix across R2-R9
    for (int it = 0; it < 60; it++) begin
      bit pe, info, ok;
      logic [8:0] a;
      logic [5:0] ia;
      logic [1:0] be;
      logic [15:0] d;
      clr_perr();
      pe = ($urandom % 8) != 0;
      wp = ($urandom % 6) == 0;
      sect_we = 8'($urandom);
      boot_top = 9'($urandom % 40);
      info = ($urandom % 3) == 0;
      be = (($urandom % 5) == 0) ? 2'($urandom) : 2'b11;
      d = 16'($urandom);
      a = 9'($urandom); if ($urandom % 5 != 0) a[0] = 1'b0;
      ia = 6'($urandom); if ($urandom % 5 != 0) ia[0] = 1'b0;
      prog_en = pe;
      if (info) begin
        wr(2'd1, 9'd0, 2'b11, {10'h0, ia});
        wr(2'd2, 9'd0, be, d);
        ok = info_ok(ia, be);
      end else begin
        wr(2'd0, a, be, d);
        ok = main_ok(a, be);
      end
      idle();
      chk("R5-R9 random perr", {31'h0, perr}, {31'h0, pe && !ok});
      if (info) begin
        if (pe && ok) exp_info[ia[5:1]] &= d;
        chk_info("R9 random info word", int'(ia[5:1]));
      end else begin
        if (pe && ok) exp_main[a[8:1]] &= d;
        chk_main("R3 random main word", int'(a[8:1]));
      end
    end
    finish_run();
  end
endmodule